// File: doc/BRIEF.md
# Three-Wire Serial Memory Shifter

This block lets a processor talk to an external serial memory over a clock line and a single shared data line. Software first places a byte in the data register. It then writes a control byte that gives the number of bits to move, the direction, and whether the data line is released after a write. That control write starts the command. The engine produces the serial clock for the requested number of bits. It either drives the register contents out most significant bit first, or it collects the bits that the memory returns.

While a command runs, a busy flag is set. When the command ends, a one-cycle interrupt pulse is raised. A command with a length of zero moves no bits and only sets whether the data line is driven. Chip select is not part of this block: software drives it from some spare pin.

Top module: `sermem_shifter`

## Requirements
- R1: A register write to address 1 while idle starts a command. Bits [3:0] of the byte are the bit count, bit 4 selects the direction (1 = write out, 0 = read in) and bit 5 is the release flag. Counts from 9 to 15 act as 8.
- R2: On a write command, `sd_o` presents data register bit 7, then each following bit in turn, most significant first. `sd_o` changes only while `sck_o` is low and holds steady through each high phase.
- R3: Each bit takes one serial clock period of 2*HALF_PERIOD system cycles, with the low phase first. Exactly count rising edges of `sck_o` occur, and `sck_o` rests low whenever no command runs.
- R4: A command with count 0 produces no serial clock and never sets busy. It leaves `sd_oe_o` equal to the inverse of its release flag.
- R5: On a write command, `sd_oe_o` is high for the whole transfer. After the last bit it falls if the release flag was 1 and stays high if the flag was 0.
- R6: On a read command, `sd_oe_o` is low for the whole transfer and after it. `sd_i` is sampled as `sck_o` rises and shifted into data register bit 0. After N bits, the first received bit sits at bit N-1 and the last at bit 0, with the earlier contents shifted up by N.
- R7: Busy (`busy_o`, and bit 0 of a read at address 1) is high from the cycle after the control write for exactly count*2*HALF_PERIOD cycles. A read at address 0 returns the data register.
- R8: `done_irq_o` pulses high for exactly one cycle when a command completes, including a zero-count command. Busy never falls without this pulse.
- R9: Register writes to either address are ignored while busy. The running command is neither restarted nor extended, and the data register is not overwritten.
- R10: After reset, `sck_o`, `sd_oe_o`, `busy_o` and `done_irq_o` are low and the data register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Write address: 0 data, 1 control |
| reg_wdata_i | input | 8 | Write data |
| reg_raddr_i | input | 1 | Read address: 0 data, 1 status |
| reg_rdata_o | output | 8 | Read data |
| sck_o | output | 1 | Serial clock to the memory |
| sd_o | output | 1 | Serial data driven to the memory |
| sd_oe_o | output | 1 | Output enable for the shared data line |
| sd_i | input | 1 | Serial data returned by the memory |
| busy_o | output | 1 | Command in progress |
| done_irq_o | output | 1 | One-cycle completion interrupt |

## Verification
The checker watches four behaviours on every cycle:
- the serial clock rests low when idle;
- outgoing data holds through each high clock phase;
- busy can only rise after a control write;
- the completion pulse is a single cycle and always goes with the fall of busy.

Several behaviours depend on a whole command and are shown only by the bench's scenarios:
- the exact bit order on the line;
- the right-justified placement of received bits;
- the length of busy in cycles;
- the release of the data line after a write;
- that writes made while busy have no effect;
- that oversized counts are clamped.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

    // Register addresses on the processor port.
    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    // Sequencer phases: idle, serial clock low, serial clock high.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sermem_halfbit_timer.sv
module sermem_halfbit_timer #(
    parameter int HALF_PERIOD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int TW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(HALF_PERIOD - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart_i || !run_i) begin
            tmr_d.cnt = RELOAD;
        end else if (tmr_q.cnt == '0) begin
            tmr_d.cnt = RELOAD;
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{cnt: RELOAD};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // End of a half period of the serial clock.
    assign tick_o = run_i && (tmr_q.cnt == '0);

endmodule

// File: rtl/sermem_seq.sv
module sermem_seq
    import sermem_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_dir_i,
    input  logic             release_i,
    input  logic             tick_i,
    output logic             busy_o,
    output logic             sck_o,
    output logic             oe_o,
    output logic             irq_o,
    output logic             sample_o,
    output logic             advance_o
);
    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] left;
        logic             sck;
        logic             oe;
        logic             wr_dir;
        logic             rel;
        logic             irq;
    } seq_t;

    seq_t seq_d, seq_q;
    logic sample_c, advance_c;

    always_comb begin
        seq_d     = seq_q;
        seq_d.irq = 1'b0;
        sample_c  = 1'b0;
        advance_c = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.wr_dir = wr_dir_i;
                    seq_d.rel    = release_i;
                    if (cnt_i == '0) begin
                        // Zero-length command: set the line drive only.
                        seq_d.oe  = !release_i;
                        seq_d.irq = 1'b1;
                    end else begin
                        seq_d.state = ST_LOW;
                        seq_d.left  = cnt_i;
                        seq_d.sck   = 1'b0;
                        seq_d.oe    = wr_dir_i;
                    end
                end
            end
            ST_LOW: begin
                if (tick_i) begin
                    seq_d.state = ST_HIGH;
                    seq_d.sck   = 1'b1;
                    sample_c    = !seq_q.wr_dir;
                end
            end
            ST_HIGH: begin
                if (tick_i) begin
                    seq_d.sck  = 1'b0;
                    advance_c  = seq_q.wr_dir;
                    seq_d.left = seq_q.left - 1'b1;
                    if (seq_q.left == CNT_W'(1)) begin
                        seq_d.state = ST_IDLE;
                        seq_d.irq   = 1'b1;
                        seq_d.oe    = seq_q.wr_dir && !seq_q.rel;
                    end else begin
                        seq_d.state = ST_LOW;
                    end
                end
            end
            default: begin
                seq_d.state = ST_IDLE;
                seq_d.sck   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, left: '0, sck: 1'b0, oe: 1'b0,
                       wr_dir: 1'b0, rel: 1'b0, irq: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o    = (seq_q.state != ST_IDLE);
    assign sck_o     = seq_q.sck;
    assign oe_o      = seq_q.oe;
    assign irq_o     = seq_q.irq;
    assign sample_o  = sample_c;
    assign advance_o = advance_c;

endmodule

// File: rtl/sermem_shreg.sv
module sermem_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              sample_i,
    input  logic              sd_i,
    input  logic              advance_i,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.data = load_val_i;
        end else if (sample_i) begin
            // Incoming bit enters at the bottom; older bits move up.
            sh_d.data = {sh_q.data[DATA_W-2:0], sd_i};
        end else if (advance_i) begin
            // Next outgoing bit moves to the top.
            sh_d.data = {sh_q.data[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '{data: '0};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign data_o = sh_q.data;

endmodule

// File: rtl/sermem_shifter.sv
module sermem_shifter
    import sermem_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int HALF_PERIOD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic              reg_raddr_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              sck_o,
    output logic              sd_o,
    output logic              sd_oe_o,
    input  logic              sd_i,
    output logic              busy_o,
    output logic              done_irq_o
);
    localparam int CNT_W   = $clog2(DATA_W + 1);
    localparam int DIR_BIT = CNT_W;
    localparam int REL_BIT = CNT_W + 1;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic             busy;
    logic             ctrl_go, data_go;
    logic [CNT_W-1:0] cnt_field, cnt_eff;
    logic             tick, sample, advance;
    logic [DATA_W-1:0] data;

    assign ctrl_go   = reg_wr_i && (reg_addr_i == ADDR_CTRL) && !busy;
    assign data_go   = reg_wr_i && (reg_addr_i == ADDR_DATA) && !busy;
    assign cnt_field = reg_wdata_i[CNT_W-1:0];

    // Clamp only when the count field can exceed the register width.
    generate
        if (CNT_MAX > DATA_W) begin : g_clamp
            assign cnt_eff = (cnt_field > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : cnt_field;
        end else begin : g_direct
            assign cnt_eff = cnt_field;
        end
    endgenerate

    sermem_halfbit_timer #(
        .HALF_PERIOD (HALF_PERIOD)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (busy),
        .restart_i (ctrl_go),
        .tick_o    (tick)
    );

    sermem_seq #(
        .CNT_W (CNT_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (ctrl_go),
        .cnt_i     (cnt_eff),
        .wr_dir_i  (reg_wdata_i[DIR_BIT]),
        .release_i (reg_wdata_i[REL_BIT]),
        .tick_i    (tick),
        .busy_o    (busy),
        .sck_o     (sck_o),
        .oe_o      (sd_oe_o),
        .irq_o     (done_irq_o),
        .sample_o  (sample),
        .advance_o (advance)
    );

    sermem_shreg #(
        .DATA_W (DATA_W)
    ) shreg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (data_go),
        .load_val_i (reg_wdata_i),
        .sample_i   (sample),
        .sd_i       (sd_i),
        .advance_i  (advance),
        .data_o     (data)
    );

    always_comb begin
        if (reg_raddr_i == ADDR_DATA) begin
            reg_rdata_o = data;
        end else begin
            reg_rdata_o = {{(DATA_W-1){1'b0}}, busy};
        end
    end

    assign sd_o   = data[DATA_W-1];
    assign busy_o = busy;

endmodule

// File: rtl/sermem_shifter_chk.sv
module sermem_shifter_chk (
    input logic clk,
    input logic rst_n,
    input logic reg_wr_i,
    input logic reg_addr_i,
    input logic sck_o,
    input logic sd_o,
    input logic busy_o,
    input logic done_irq_o
);
    // R7: busy only rises after a control write.
    p_busy_from_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(reg_wr_i && reg_addr_i));

    // R3: serial clock rests low while idle.
    p_sck_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sck_o);

    // R2: outgoing data holds through a high phase.
    p_sd_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(sd_o));

    // R8: the completion pulse lasts one cycle.
    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |=> !done_irq_o);

    // R8: busy never ends without the completion pulse.
    p_busy_end_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_irq_o);

endmodule

bind sermem_shifter sermem_shifter_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .sck_o      (sck_o),
    .sd_o       (sd_o),
    .busy_o     (busy_o),
    .done_irq_o (done_irq_o)
);

// File: tb/sermem_shifter_tb_top.sv
module sermem_shifter_tb_top;
    localparam int HP  = 2;
    localparam int BIT = 2 * HP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic       reg_addr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic       reg_raddr_i = 1'b0;
    logic [7:0] reg_rdata_o;
    logic       sck_o, sd_o, sd_oe_o, busy_o, done_irq_o;
    logic       sd_i = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // Monitor state
    logic       prev_sck = 1'b0;
    logic [7:0] cap = '0;
    logic [7:0] rd_pat = '0;
    int rises = 0, last_rise = 0, gap_bad = 0;
    int busy_cyc = 0, oe_busy = 0, irq_cnt = 0;

    sermem_shifter #(.DATA_W(8), .HALF_PERIOD(HP)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_raddr_i (reg_raddr_i),
        .reg_rdata_o (reg_rdata_o),
        .sck_o       (sck_o),
        .sd_o        (sd_o),
        .sd_oe_o     (sd_oe_o),
        .sd_i        (sd_i),
        .busy_o      (busy_o),
        .done_irq_o  (done_irq_o)
    );

    always #4 clk = ~clk;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    // Memory model and line monitor, all at the falling system clock edge.
    always @(negedge clk) begin
        if (sck_o && !prev_sck) begin
            cap = {cap[6:0], sd_o};
            if (rises > 0 && (cyc - last_rise) != BIT) gap_bad++;
            last_rise = cyc;
            rises++;
        end
        prev_sck = sck_o;
        if (busy_o) busy_cyc++;
        if (busy_o && sd_oe_o) oe_busy++;
        if (done_irq_o) irq_cnt++;
        sd_i = (rises < 8) ? rd_pat[7 - rises] : 1'b0;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic addr, input logic [7:0] val);
        @(negedge clk);
        reg_wr_i    = 1'b1;
        reg_addr_i  = addr;
        reg_wdata_i = val;
        @(negedge clk);
        reg_wr_i    = 1'b0;
    endtask

    task automatic read_reg(input logic addr, output logic [7:0] val);
        @(negedge clk);
        reg_raddr_i = addr;
        #1;
        val = reg_rdata_o;
    endtask

    task automatic clear_mon();
        cap = '0; rises = 0; gap_bad = 0;
        busy_cyc = 0; oe_busy = 0; irq_cnt = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R10 sck", sck_o, 0);
        chk("R10 oe", sd_oe_o, 0);
        chk("R10 busy", busy_o, 0);
        chk("R10 irq", done_irq_o, 0);
        read_reg(1'b0, v);
        chk("R10 data", v, 0);
    endtask

    // Write command; control byte bit 4 = write, bit 5 = release.
    task automatic t_write(input logic [7:0] val, input int n, input logic rel);
        logic [7:0] exp;
        clear_mon();
        write_reg(1'b0, val);
        write_reg(1'b1, 8'(n) | 8'h10 | (rel ? 8'h20 : 8'h00));
        wait_idle();
        exp = 8'(val >> (8 - n));
        chk("R2 bits out", int'(cap & 8'((1 << n) - 1)), int'(exp));
        chk("R3 rises", rises, n);
        chk("R3 period", gap_bad, 0);
        chk("R7 busy length", busy_cyc, n * BIT);
        chk("R5 oe during", oe_busy, n * BIT);
        chk("R5 oe after", sd_oe_o, rel ? 0 : 1);
        chk("R8 irq count", irq_cnt, 1);
    endtask

    task automatic t_read(input logic [7:0] init, input logic [7:0] pat, input int n);
        logic [7:0] v, exp;
        clear_mon();
        rd_pat = pat;
        write_reg(1'b0, init);
        write_reg(1'b1, 8'(n));
        wait_idle();
        exp = 8'((16'(init) << n) | (16'(pat) >> (8 - n)));
        read_reg(1'b0, v);
        chk("R6 data in", v, exp);
        chk("R6 oe low", oe_busy, 0);
        chk("R6 oe after", sd_oe_o, 0);
        chk("R7 busy length", busy_cyc, n * BIT);
    endtask

    task automatic t_zero(input logic rel);
        clear_mon();
        write_reg(1'b1, 8'h10 | (rel ? 8'h20 : 8'h00));
        wait_idle();
        chk("R4 no clock", rises, 0);
        chk("R4 no busy", busy_cyc, 0);
        chk("R4 oe", sd_oe_o, rel ? 0 : 1);
        chk("R8 zero irq", irq_cnt, 1);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        clear_mon();
        write_reg(1'b0, 8'hC3);
        write_reg(1'b1, 8'h38);
        repeat (6) @(negedge clk);
        read_reg(1'b1, v);
        chk("R7 status busy", v, 1);
        write_reg(1'b0, 8'h5A);
        write_reg(1'b1, 8'h38);
        wait_idle();
        chk("R9 bits out", cap, 8'hC3);
        chk("R9 busy length", busy_cyc, 8 * BIT);
        read_reg(1'b0, v);
        chk("R9 data kept", v, 0);
        read_reg(1'b1, v);
        chk("R7 status idle", v, 0);
    endtask

    task automatic t_clamp();
        clear_mon();
        write_reg(1'b0, 8'h96);
        write_reg(1'b1, 8'h1F);
        wait_idle();
        chk("R1 clamp rises", rises, 8);
        chk("R1 clamp bits", cap, 8'h96);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write(8'hA5, 8, 1'b1);
        t_write(8'h6C, 3, 1'b0);
        t_write(8'h81, 1, 1'b1);
        t_read(8'h00, 8'hB2, 8);
        t_read(8'hF0, 8'h40, 3);
        t_zero(1'b0);
        t_zero(1'b1);
        t_busy_ignore();
        t_clamp();
        finish_run();
    end

endmodule